// File: doc/BRIEF.md
# I2C Write-Only Slave for an 8-bit DAC Code Register

This block sits behind the two-wire pins of a single-channel 8-bit converter and turns bus write traffic into register updates. A fast system clock oversamples the clock and data lines. Each line passes through a two-stage synchroniser and a majority-free run-length filter. Edge logic then finds start, repeated start and stop conditions and the rising and falling edges of the bus clock. The slave answers to a 7-bit address built from a fixed 6-bit prefix and a strap bit latched while reset is held. It also answers to one broadcast address. It acknowledges by asserting an open-drain pull-down enable on the data line.

After an accepted write address, the slave takes bytes in pairs. The first byte of a pair carries a 2-bit power-down selector and the upper data nibble. The second byte carries the lower data nibble. The new code and selector are applied together, with a single-cycle strobe, when the acknowledge clock after the second byte ends. Further pairs may follow in the same transfer without re-addressing. A high-speed master code is recognised and flagged but never acknowledged.

Top module: `i2cdac_wr_slave`

## Requirements
- R1: While reset is held and right after it, data_code and pd are 0, and update_pulse, sda_oe and hs_mode are low.
- R2: An address byte whose top seven bits equal the prefix (default 100110) followed by the strap bit is acknowledged when its last bit (R/W) is 0. The strap bit is the value of a0_pin captured during reset; later changes on a0_pin have no effect.
- R3: The broadcast address byte 1001_0000 is acknowledged whatever the latched strap value.
- R4: An address byte that matches neither address, or that has R/W = 1, is not acknowledged. Every byte up to the next START is then ignored: no acknowledge and no update.
- R5: The slave holds sda_oe steady for the whole high phase of each bus clock, so an acknowledge keeps SDA low for the entire ninth clock high period.
- R6: In the first byte of a pair, bits 5:4 give pd and bits 3:0 give data_code[7:4]. Bits 7:6 are ignored, but the byte is still acknowledged. In the second byte, bits 7:4 give data_code[3:0] and bits 3:0 are ignored.
- R7: data_code and pd change only together with a one-cycle update_pulse. The pulse is raised on the bus clock falling edge that ends the acknowledge clock after the second byte of a pair.
- R8: Pairs that follow one another in a single transfer, without a new START or address, each produce their own update.
- R9: A first byte of the form 00001xxx is not acknowledged and sets hs_mode. hs_mode stays set across repeated STARTs and clears at the next STOP. After a repeated START, a normal address is accepted.
- R10: A START or STOP inside a byte ends the frame, and the partly received pair produces no update.
- R11: A data-line pulse shorter than the filter length while the bus clock is high is not taken as a START or STOP and does not corrupt the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset; the strap bit is captured while it is low |
| a0_pin | input | 1 | Address strap bit |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls the data line low |
| data_code | output | 8 | Applied converter code |
| pd | output | 2 | Applied power-down selector (0 = normal) |
| update_pulse | output | 1 | One-cycle strobe when data_code and pd take a new value |
| hs_mode | output | 1 | High-speed master code seen since the last STOP |

## Verification
The bench builds the slave with its default parameters: prefix 100110, broadcast 1001000 and a three-sample filter. It drives the bus with a clock half-period of twelve system clocks. That is long enough for the synchroniser and filter delay to settle inside each phase. It is also long enough that a one-cycle data glitch falls under the filter length, so the glitch case can be exercised. The strap is held at 1 during reset and moved to 0 afterwards, which puts both the latched-strap rule and the broadcast path within reach.

// File: rtl/i2cdac_pkg.sv
package i2cdac_pkg;
   localparam int BYTE_W = 8;
   localparam int NIB_W  = 4;
   localparam int PD_W   = 2;
   localparam logic [4:0] HS_TAG = 5'b00001;

   typedef enum logic [1:0] {
      PH_ADDR = 2'd0,
      PH_HI   = 2'd1,
      PH_LO   = 2'd2
   } phase_t;
endpackage

// File: rtl/i2cdac_in_filt.sv
module i2cdac_in_filt #(
   parameter int   FILT_LEN = 3,
   parameter logic RST_VAL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [1:0] sy;

   initial assert (FILT_LEN >= 0 && FILT_LEN <= 16)
      else $error("i2cdac_in_filt: FILT_LEN out of range");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sy <= {2{RST_VAL}};
      else        sy <= {sy[0], din};
   end

   generate
      if (FILT_LEN < 2) begin : g_bypass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dout <= RST_VAL;
            else        dout <= sy[1];
         end
      end else begin : g_runlen
         logic [FILT_LEN-1:0] hist;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist <= {FILT_LEN{RST_VAL}};
               dout <= RST_VAL;
            end else begin
               hist <= {hist[FILT_LEN-2:0], sy[1]};
               if (&hist)       dout <= 1'b1;
               else if (~|hist) dout <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/i2cdac_bus_cond.sv
module i2cdac_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   always_comb begin
      scl_rise  = scl_f & ~scl_q;
      scl_fall  = ~scl_f & scl_q;
      start_det = scl_f & scl_q & sda_q & ~sda_f;
      stop_det  = scl_f & scl_q & ~sda_q & sda_f;
   end
endmodule

// File: rtl/i2cdac_wr_slave.sv
module i2cdac_wr_slave
   import i2cdac_pkg::*;
#(
   parameter int             PFX_W       = 6,
   parameter logic [PFX_W-1:0] ADDR_PREFIX = 6'b100110,
   parameter logic [PFX_W:0]   BCAST_ADDR  = 7'b1001000,
   parameter int             FILT_LEN    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a0_pin,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [BYTE_W-1:0] data_code,
   output logic [PD_W-1:0]   pd,
   output logic              update_pulse,
   output logic              hs_mode
);
   localparam int ADDR_W = PFX_W + 1;
   localparam int CNT_W  = $clog2(BYTE_W + 2);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);

   initial assert (ADDR_W == BYTE_W - 1)
      else $error("i2cdac_wr_slave: address must be one bit shorter than a byte");

   logic scl_f, sda_f, scl_rise, scl_fall, start_det, stop_det;

   i2cdac_in_filt #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_scl_filt (
      .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f));
   i2cdac_in_filt #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_sda_filt (
      .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f));

   i2cdac_bus_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   logic              a0_lat, active;
   phase_t            phase;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] shreg;
   logic [NIB_W-1:0]  hi_nib;
   logic [PD_W-1:0]   pd_pend;
   logic              addr_hit, hs_hit;

   always_comb begin
      addr_hit = (shreg[BYTE_W-1:1] == {ADDR_PREFIX, a0_lat}) ||
                 (shreg[BYTE_W-1:1] == BCAST_ADDR);
      hs_hit   = (shreg[BYTE_W-1:BYTE_W-5] == HS_TAG);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a0_lat       <= a0_pin;
         active       <= 1'b0;
         phase        <= PH_ADDR;
         cnt          <= '0;
         shreg        <= '0;
         hi_nib       <= '0;
         pd_pend      <= '0;
         sda_oe       <= 1'b0;
         hs_mode      <= 1'b0;
         data_code    <= '0;
         pd           <= '0;
         update_pulse <= 1'b0;
      end else begin
         update_pulse <= 1'b0;
         if (stop_det) begin
            active  <= 1'b0;
            sda_oe  <= 1'b0;
            hs_mode <= 1'b0;
            cnt     <= '0;
         end else if (start_det) begin
            active <= 1'b1;
            phase  <= PH_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (active) begin
            if (scl_rise && cnt < CNT_LAST) begin
               shreg <= {shreg[BYTE_W-2:0], sda_f};
               cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_LAST) begin
               case (phase)
                  PH_ADDR: begin
                     if (hs_hit) begin
                        hs_mode <= 1'b1;
                        active  <= 1'b0;
                     end else if (addr_hit && !shreg[0]) begin
                        sda_oe <= 1'b1;
                        cnt    <= CNT_ACK;
                     end else begin
                        active <= 1'b0;
                     end
                  end
                  PH_HI: begin
                     pd_pend <= shreg[NIB_W+PD_W-1:NIB_W];
                     hi_nib  <= shreg[NIB_W-1:0];
                     sda_oe  <= 1'b1;
                     cnt     <= CNT_ACK;
                  end
                  default: begin
                     sda_oe <= 1'b1;
                     cnt    <= CNT_ACK;
                  end
               endcase
            end else if (scl_fall && cnt == CNT_ACK) begin
               sda_oe <= 1'b0;
               cnt    <= '0;
               case (phase)
                  PH_ADDR: phase <= PH_HI;
                  PH_HI:   phase <= PH_LO;
                  default: begin
                     phase        <= PH_HI;
                     data_code    <= {hi_nib, shreg[BYTE_W-1:NIB_W]};
                     pd           <= pd_pend;
                     update_pulse <= 1'b1;
                  end
               endcase
            end
         end
      end
   end

   // R7
   upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      update_pulse |=> !update_pulse);

   // R7
   upd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      update_pulse |-> $past(scl_fall));

   // R5
   ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_f && $past(scl_f)) |-> $stable(sda_oe));

   // R9
   hs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !hs_mode);

   // R10
   start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe);
endmodule

// File: tb/tb_i2cdac_wr_slave.sv
module tb_i2cdac_wr_slave;
   localparam int H  = 12;
   localparam int WD = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic a0_pin = 1'b1;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe, update_pulse, hs_mode;
   logic [7:0] data_code;
   logic [1:0] pd;
   logic sda_line;

   always #10 clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   i2cdac_wr_slave dut (
      .clk(clk), .rst_n(rst_n), .a0_pin(a0_pin), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .data_code(data_code), .pd(pd),
      .update_pulse(update_pulse), .hs_mode(hs_mode));

   int n_chk = 0;
   int n_fail = 0;
   logic [9:0] exp_q[$];
   logic [9:0] exp_item;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && update_pulse) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R4/R10 unexpected update act=%0h exp=none", {pd, data_code});
         end else begin
            exp_item = exp_q.pop_front();
            if ({pd, data_code} !== exp_item) begin
               n_fail++;
               $display("FAIL R6/R7 update value act=%0h exp=%0h", {pd, data_code}, exp_item);
            end
         end
      end
   end

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; ticks(H);
      sda_m = 1'b0; ticks(H);
      scl_m = 1'b0;
   endtask

   task automatic bus_rstart();
      ticks(2); sda_m = 1'b1; ticks(H-2);
      scl_m = 1'b1; ticks(H);
      sda_m = 1'b0; ticks(H);
      scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      ticks(2); sda_m = 1'b0; ticks(H-2);
      scl_m = 1'b1; ticks(H);
      sda_m = 1'b1; ticks(H);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n, input int glitch);
      for (int i = 0; i < n; i++) begin
         ticks(2); sda_m = b[7-i]; ticks(H-2);
         scl_m = 1'b1;
         if (i == glitch) begin
            ticks(H/2); sda_m = 1'b0; ticks(1); sda_m = b[7-i]; ticks(H - H/2 - 1);
         end else begin
            ticks(H);
         end
         scl_m = 1'b0;
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag,
                            input int glitch);
      logic s1, s2;
      send_bits(b, 8, glitch);
      ticks(2); sda_m = 1'b1; ticks(H-2);
      scl_m = 1'b1;
      ticks(1); s1 = sda_line;
      ticks(H-2); s2 = sda_line;
      ticks(1);
      scl_m = 1'b0;
      // R5: acknowledge must cover both ends of the high phase
      chk((!s1 && !s2) == exp_ack && (s1 == s2), tag, {s1, s2}, exp_ack ? 0 : 3);
   endtask

   task automatic send_word(input logic [7:0] hi, input logic [7:0] lo, input bit acked,
                            input int glitch);
      send_byte(hi, acked, "R6 first byte ack", -1);
      if (acked) exp_q.push_back({hi[5:4], hi[3:0], lo[7:4]});
      send_byte(lo, acked, "R6 second byte ack", glitch);
   endtask

   initial begin
      ticks(WD);
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=done", WD);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      ticks(5);
      // R1 reset state
      chk(data_code == 8'h00, "R1 code at reset", data_code, 0);
      chk(pd == 2'd0, "R1 pd at reset", pd, 0);
      chk(!sda_oe && !update_pulse && !hs_mode, "R1 flags at reset",
          {sda_oe, update_pulse, hs_mode}, 0);
      rst_n = 1'b1;
      ticks(3);
      a0_pin = 1'b0;
      ticks(10);
      chk(data_code == 8'h00 && pd == 2'd0 && !sda_oe, "R1 after reset",
          {pd, data_code, sda_oe}, 0);

      // R2: own address with latched strap = 1
      bus_start();
      send_byte(8'h9A, 1'b1, "R2 own address ack", -1);
      send_word(8'h2A, 8'h5F, 1'b1, -1);
      bus_stop(); ticks(20);
      chk(data_code == 8'hA5 && pd == 2'd2, "R6 fields applied", {pd, data_code}, 10'h2A5);

      // R2/R4: strap changed after reset has no effect
      bus_start();
      send_byte(8'h98, 1'b0, "R2 strap pin ignored after reset", -1);
      send_word(8'h11, 8'h22, 1'b0, -1);
      bus_stop(); ticks(20);
      chk(data_code == 8'hA5, "R4 no update after nak", data_code, 8'hA5);

      // R3 broadcast, R8 streaming
      bus_start();
      send_byte(8'h90, 1'b1, "R3 broadcast ack", -1);
      send_word(8'hC3, 8'h3C, 1'b1, -1);
      ticks(20);
      chk(data_code == 8'h33 && pd == 2'd0, "R6 top bits ignored", {pd, data_code}, 10'h033);
      send_word(8'h11, 8'hE0, 1'b1, -1);
      ticks(20);
      chk(data_code == 8'h1E && pd == 2'd1, "R8 second pair applied", {pd, data_code}, 10'h11E);
      bus_stop(); ticks(20);

      // R4: read direction and wrong address
      bus_start();
      send_byte(8'h9B, 1'b0, "R4 read direction nak", -1);
      bus_stop(); ticks(20);
      bus_start();
      send_byte(8'h9C, 1'b0, "R4 wrong address nak", -1);
      send_byte(8'h05, 1'b0, "R4 following byte ignored", -1);
      bus_stop(); ticks(20);

      // R9 high-speed master code
      bus_start();
      send_byte(8'h09, 1'b0, "R9 master code not acked", -1);
      chk(hs_mode == 1'b1, "R9 hs_mode set", hs_mode, 1);
      bus_rstart();
      send_byte(8'h9A, 1'b1, "R9 address after repeated start", -1);
      send_word(8'h03, 8'hF0, 1'b1, -1);
      ticks(20);
      chk(hs_mode == 1'b1 && data_code == 8'h3F, "R9 hs kept, write done",
          {hs_mode, data_code}, 9'h13F);
      bus_stop(); ticks(20);
      chk(hs_mode == 1'b0, "R9 hs cleared by stop", hs_mode, 0);

      // R10: stop inside second byte
      bus_start();
      send_byte(8'h9A, 1'b1, "R10 address ack", -1);
      send_byte(8'h1F, 1'b1, "R10 first byte ack", -1);
      send_bits(8'h55, 4, -1);
      bus_stop(); ticks(20);
      chk(data_code == 8'h3F && pd == 2'd0, "R10 stop discards pair", {pd, data_code}, 10'h03F);

      // R10: repeated start inside a byte
      bus_start();
      send_byte(8'h9A, 1'b1, "R10 address ack", -1);
      send_byte(8'h30, 1'b1, "R10 first byte ack", -1);
      send_bits(8'hFF, 3, -1);
      bus_rstart();
      send_byte(8'h9A, 1'b1, "R10 readdress ack", -1);
      send_word(8'h00, 8'h10, 1'b1, -1);
      ticks(20);
      chk(data_code == 8'h01 && pd == 2'd0, "R10 fresh pair only", {pd, data_code}, 10'h001);
      bus_stop(); ticks(20);

      // R11: short data glitch while clock high
      bus_start();
      send_byte(8'h9A, 1'b1, "R11 address ack", -1);
      send_word(8'h20, 8'hFF, 1'b1, 2);
      ticks(20);
      chk(data_code == 8'h0F && pd == 2'd2, "R11 glitch ignored", {pd, data_code}, 10'h20F);
      bus_stop(); ticks(40);

      chk(exp_q.size() == 0, "R7 every expected update seen", exp_q.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule